// File: doc/BRIEF.md
# I/O Translation Entry Checker

This block takes a 128-bit device table entry that has already been fetched, together with the request that needs it: a device number, an I/O virtual address, an access class and the read/write permission the access asks for. In one registered step it picks a single outcome from a fixed ranking. The outcome is one of: forward the address untranslated, reject the entry as illegal, report a page fault, grant access with the entry's own permission bits, or hand off to a deeper table walk once the first level has passed its presence and permission test.

Every outcome comes with a result code and the permission granted. Illegal-entry and page-fault outcomes also carry an error descriptor that a downstream event builder turns into a log record. An external comparator performs the exclusion-range comparison and delivers it as one hit bit. Memory fetches, lower walk levels and translation caching are handled by neighbouring blocks.

Top module: `xlt_entry_check`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one cycle of `out_valid` on the following clock, carrying that request's outcome. Each cycle with `req_valid` low produces `out_valid` low on the following clock.
- R2: When entry bit 0 (valid) is clear, the result is PASS (code 0), `grant_perm` is 2'b11, `err_valid` is 0 and all error fields are zero. This holds even if reserved bits are set.
- R3: With the valid bit set, a set quadword-0 bit outside 0x7fffffffffffff83 gives ILLEGAL (code 1), cause RSVD (1), `err_rsvd`=1, `err_present`=0, `grant_perm`=0 and `err_addr` equal to the address with bits 1:0 cleared.
- R4: Feature bits count as reserved. Any set bit in quadword-0 bits 60:52 or quadword-1 bits 31:16 of a valid entry gives ILLEGAL.
- R5: With the valid bit set, a set quadword-1 bit outside 0xfffffbffffffffff gives ILLEGAL. Quadword-1 bits 15:0 are allowed.
- R6: When both `excl_en` and `excl_hit` are high, a valid entry with no reserved bits gives PASS. This check ranks below the reserved-bit check. Either input alone has no effect.
- R7: When translation-valid (bit 1) is clear, the result is FAULT (code 2), cause TV_OFF (2), with `err_present`=0, `err_rsvd`=0 and `grant_perm`=0.
- R8: A mode field (bits 11:9) of 0 gives GRANT (code 3), with `grant_perm` = {bit 62 write, bit 61 read}. The requested permission is not compared.
- R9: A mode above `MAX_LEVEL` (default 6) gives FAULT with cause BAD_LEVEL (3) and `err_present`=1. A mode of exactly `MAX_LEVEL` does not fault on level.
- R10: When the entry's permissions (`grant_perm` bit 0 read, bit 1 write) miss any requested bit, the result is FAULT with `err_present`=1 and `grant_perm`=0. The cause is WRITE_PROT (5) if write was requested and READ_PROT (4) otherwise.
- R11: A valid entry that passes every check with a non-zero mode gives WALK (code 4), with `grant_perm` equal to the entry's permissions and `err_valid`=0.
- R12: On ILLEGAL or FAULT, `err_valid`=1, `err_dev_id` copies `dev_id`, and `err_write`, `err_intr` and `err_xlate` are set for op WRITE (1), INTR (2) and XLATE (3) respectively; READ is 0 and CMD is 4. A fault reports the full address.
- R13: During reset, `out_valid`, `result`, `grant_perm`, `err_valid` and `err_cause` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| entry_lo | input | 64 | Entry quadword 0 |
| entry_hi | input | 64 | Entry quadword 1 |
| dev_id | input | DEVID_W | Requesting device number |
| iova | input | ADDR_W | I/O virtual address |
| op | input | 3 | Access class: 0 read, 1 write, 2 interrupt, 3 translate, 4 command |
| req_perm | input | 2 | Requested permission, bit 0 read, bit 1 write |
| excl_en | input | 1 | Exclusion range enabled |
| excl_hit | input | 1 | Address lies in the exclusion range |
| out_valid | output | 1 | Outcome strobe |
| result | output | 3 | 0 pass, 1 illegal, 2 fault, 3 grant, 4 walk |
| grant_perm | output | 2 | Permission granted |
| err_valid | output | 1 | Error descriptor present |
| err_cause | output | 3 | 0 none, 1 rsvd, 2 tv_off, 3 bad_level, 4 read_prot, 5 write_prot |
| err_present | output | 1 | Fault on a present entry |
| err_rsvd | output | 1 | Reserved bits were non-zero |
| err_write | output | 1 | Access was a write |
| err_intr | output | 1 | Access was an interrupt |
| err_xlate | output | 1 | Access was a translate request |
| err_dev_id | output | DEVID_W | Device number of the failing request |
| err_addr | output | ADDR_W | Reported address |

## Verification
The assertions assume that `op` holds one of the five defined codes and that the entry, address and side inputs are settled for the whole cycle in which `req_valid` is high. They make no assumption about the reserved bits, because reserved-bit screening is the block's own job. The stimulus drives every input on the falling edge, holds it through exactly one rising edge and uses only the five defined access classes. Side inputs such as `excl_hit` are toggled independently, so that their interaction with the ranking is exercised.

// File: rtl/xlt_chk_pkg.sv
package xlt_chk_pkg;

   typedef enum logic [2:0] {
      RES_PASS    = 3'd0,
      RES_ILLEGAL = 3'd1,
      RES_FAULT   = 3'd2,
      RES_GRANT   = 3'd3,
      RES_WALK    = 3'd4
   } xlt_result_e;

   typedef enum logic [2:0] {
      CAUSE_NONE       = 3'd0,
      CAUSE_RSVD       = 3'd1,
      CAUSE_TV_OFF     = 3'd2,
      CAUSE_BAD_LEVEL  = 3'd3,
      CAUSE_READ_PROT  = 3'd4,
      CAUSE_WRITE_PROT = 3'd5
   } xlt_cause_e;

   typedef enum logic [2:0] {
      OP_READ  = 3'd0,
      OP_WRITE = 3'd1,
      OP_INTR  = 3'd2,
      OP_XLATE = 3'd3,
      OP_CMD   = 3'd4
   } xlt_op_e;

   // field positions that the checks decode
   localparam int ENT_VALID_BIT = 0;
   localparam int ENT_TV_BIT    = 1;
   localparam int ENT_MODE_LSB  = 9;
   localparam int ENT_MODE_W    = 3;
   localparam int ENT_RD_BIT    = 61;
   localparam int ENT_WR_BIT    = 62;

   // architecturally defined bits per quadword
   localparam logic [63:0] Q0_DEFINED = 64'h7fff_ffff_ffff_ff83;
   localparam logic [63:0] Q1_DEFINED = 64'hffff_fbff_ffff_ffff;
   // optional-feature fields, screened as reserved
   localparam logic [63:0] Q0_FEAT_A  = 64'h0030_0000_0000_0000;
   localparam logic [63:0] Q0_FEAT_B  = 64'h1f80_0000_0000_0000;
   localparam logic [63:0] Q0_FEAT_C  = 64'h0040_0000_0000_0000;
   localparam logic [63:0] Q0_FEATURE = Q0_FEAT_A | Q0_FEAT_B | Q0_FEAT_C;
   localparam logic [63:0] Q1_FEATURE = 64'h0000_0000_ffff_0000;

endpackage

// File: rtl/xlt_rsvd_scan.sv
module xlt_rsvd_scan #(
   parameter logic [63:0] DEF0  = xlt_chk_pkg::Q0_DEFINED,
   parameter logic [63:0] FEAT0 = xlt_chk_pkg::Q0_FEATURE,
   parameter logic [63:0] DEF1  = xlt_chk_pkg::Q1_DEFINED,
   parameter logic [63:0] FEAT1 = xlt_chk_pkg::Q1_FEATURE
) (
   input  logic [63:0] qw0,
   input  logic [63:0] qw1,
   output logic        rsvd_hit
);

   localparam int          NQW    = 2;
   localparam logic [63:0] ALLOW0 = DEF0 & ~FEAT0;
   localparam logic [63:0] ALLOW1 = DEF1 & ~FEAT1;

   logic [NQW-1:0] qw_bad;

   for (genvar i = 0; i < NQW; i++) begin : g_qw
      if (i == 0) begin : g_lo
         assign qw_bad[i] = |(qw0 & ~ALLOW0);
      end else begin : g_hi
         assign qw_bad[i] = |(qw1 & ~ALLOW1);
      end
   end

   assign rsvd_hit = |qw_bad;

endmodule

// File: rtl/xlt_level_perm.sv
module xlt_level_perm #(
   parameter int MAX_LEVEL = 6
) (
   input  logic [63:0] qw0,
   input  logic [1:0]  req_perm,
   output logic        mode_zero,
   output logic        level_bad,
   output logic        perm_short,
   output logic        write_asked,
   output logic [1:0]  entry_perm
);
   import xlt_chk_pkg::*;

   localparam int MODE_MAX = (1 << ENT_MODE_W) - 1;

   if (MAX_LEVEL < 1 || MAX_LEVEL > MODE_MAX) begin : g_bad_param
      $error("xlt_level_perm: MAX_LEVEL out of range");
   end

   logic [ENT_MODE_W-1:0] mode;
   logic                  present;

   assign mode       = qw0[ENT_MODE_LSB +: ENT_MODE_W];
   assign present    = qw0[ENT_VALID_BIT];
   assign entry_perm = {qw0[ENT_WR_BIT], qw0[ENT_RD_BIT]};
   assign mode_zero  = (mode == '0);

   // a full-range maximum makes every encoding legal
   if (MAX_LEVEL == MODE_MAX) begin : g_all_legal
      assign level_bad = 1'b0;
   end else begin : g_limited
      assign level_bad = (mode > ENT_MODE_W'(MAX_LEVEL));
   end

   // first walk level: the entry itself acts as the top table entity
   assign perm_short  = !present || ((req_perm & entry_perm) != req_perm);
   assign write_asked = req_perm[1];

endmodule

// File: rtl/xlt_entry_check.sv
module xlt_entry_check #(
   parameter int ADDR_W    = 64,
   parameter int DEVID_W   = 16,
   parameter int MAX_LEVEL = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [63:0]        entry_lo,
   input  logic [63:0]        entry_hi,
   input  logic [DEVID_W-1:0] dev_id,
   input  logic [ADDR_W-1:0]  iova,
   input  logic [2:0]         op,
   input  logic [1:0]         req_perm,
   input  logic               excl_en,
   input  logic               excl_hit,
   output logic               out_valid,
   output logic [2:0]         result,
   output logic [1:0]         grant_perm,
   output logic               err_valid,
   output logic [2:0]         err_cause,
   output logic               err_present,
   output logic               err_rsvd,
   output logic               err_write,
   output logic               err_intr,
   output logic               err_xlate,
   output logic [DEVID_W-1:0] err_dev_id,
   output logic [ADDR_W-1:0]  err_addr
);
   import xlt_chk_pkg::*;

   localparam logic [ADDR_W-1:0] LOW2_CLR = ~ADDR_W'(3);

   if (ADDR_W < 12) begin : g_bad_addr
      $error("xlt_entry_check: ADDR_W too small");
   end
   if (DEVID_W < 1) begin : g_bad_dev
      $error("xlt_entry_check: DEVID_W too small");
   end

   logic       rsvd_hit, mode_zero, level_bad, perm_short, write_asked;
   logic [1:0] entry_perm;

   xlt_rsvd_scan u_rsvd (
      .qw0      (entry_lo),
      .qw1      (entry_hi),
      .rsvd_hit (rsvd_hit)
   );

   xlt_level_perm #(.MAX_LEVEL(MAX_LEVEL)) u_lvl (
      .qw0         (entry_lo),
      .req_perm    (req_perm),
      .mode_zero   (mode_zero),
      .level_bad   (level_bad),
      .perm_short  (perm_short),
      .write_asked (write_asked),
      .entry_perm  (entry_perm)
   );

   xlt_result_e       n_res;
   xlt_cause_e        n_cause;
   logic [1:0]        n_perm;
   logic              n_present, n_rsvd, n_err;
   logic [ADDR_W-1:0] n_addr;

   // fixed ranking: valid, reserved, exclusion, tv, mode 0, level, permission
   always_comb begin
      n_res     = RES_PASS;
      n_cause   = CAUSE_NONE;
      n_perm    = 2'b11;
      n_present = 1'b0;
      n_rsvd    = 1'b0;
      n_addr    = '0;
      if (!entry_lo[ENT_VALID_BIT]) begin
         n_res = RES_PASS;
      end else if (rsvd_hit) begin
         n_res   = RES_ILLEGAL;
         n_cause = CAUSE_RSVD;
         n_perm  = 2'b00;
         n_rsvd  = 1'b1;
         n_addr  = iova & LOW2_CLR;
      end else if (excl_en && excl_hit) begin
         n_res = RES_PASS;
      end else if (!entry_lo[ENT_TV_BIT]) begin
         n_res   = RES_FAULT;
         n_cause = CAUSE_TV_OFF;
         n_perm  = 2'b00;
         n_addr  = iova;
      end else if (mode_zero) begin
         n_res  = RES_GRANT;
         n_perm = entry_perm;
      end else if (level_bad) begin
         n_res     = RES_FAULT;
         n_cause   = CAUSE_BAD_LEVEL;
         n_perm    = 2'b00;
         n_present = 1'b1;
         n_addr    = iova;
      end else if (perm_short) begin
         n_res     = RES_FAULT;
         n_cause   = write_asked ? CAUSE_WRITE_PROT : CAUSE_READ_PROT;
         n_perm    = 2'b00;
         n_present = 1'b1;
         n_addr    = iova;
      end else begin
         n_res  = RES_WALK;
         n_perm = entry_perm;
      end
      n_err = (n_res == RES_ILLEGAL) || (n_res == RES_FAULT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         result      <= RES_PASS;
         grant_perm  <= 2'b00;
         err_valid   <= 1'b0;
         err_cause   <= CAUSE_NONE;
         err_present <= 1'b0;
         err_rsvd    <= 1'b0;
         err_write   <= 1'b0;
         err_intr    <= 1'b0;
         err_xlate   <= 1'b0;
         err_dev_id  <= '0;
         err_addr    <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            result      <= n_res;
            grant_perm  <= n_perm;
            err_valid   <= n_err;
            err_cause   <= n_cause;
            err_present <= n_present;
            err_rsvd    <= n_rsvd;
            err_write   <= n_err && (op == OP_WRITE);
            err_intr    <= n_err && (op == OP_INTR);
            err_xlate   <= n_err && (op == OP_XLATE);
            err_dev_id  <= n_err ? dev_id : '0;
            err_addr    <= n_addr;
         end
      end
   end

   // R1
   strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   // R1
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);
   // R2
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !entry_lo[ENT_VALID_BIT]) |=> (result == RES_PASS) && !err_valid);
   // R3
   illegal_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && result == RES_ILLEGAL) |-> err_rsvd && (err_addr[1:0] == 2'b00) && err_valid);
   // R7
   fault_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && result == RES_FAULT) |-> (grant_perm == 2'b00) && err_valid && !err_rsvd);
   // R10
   prot_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (err_cause == CAUSE_READ_PROT || err_cause == CAUSE_WRITE_PROT)) |-> err_present);
   // R11
   walk_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && result == RES_WALK) |-> !err_valid && (err_cause == CAUSE_NONE));

endmodule

// File: tb/xlt_entry_check_test.sv
`timescale 1ns/1ps
module xlt_entry_check_test;

   localparam logic [63:0] BASE = 64'h6000_0000_0000_0603; // V, TV, mode 3, RD, WR

   logic        clk = 0;
   logic        rst_n = 0;
   logic        req_valid = 0;
   logic [63:0] entry_lo = 0, entry_hi = 0;
   logic [15:0] dev_id = 0;
   logic [63:0] iova = 0;
   logic [2:0]  op = 0;
   logic [1:0]  req_perm = 0;
   logic        excl_en = 0, excl_hit = 0;
   logic        out_valid, err_valid, err_present, err_rsvd, err_write, err_intr, err_xlate;
   logic [2:0]  result, err_cause;
   logic [1:0]  grant_perm;
   logic [15:0] err_dev_id;
   logic [63:0] err_addr;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   xlt_entry_check uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .entry_lo(entry_lo), .entry_hi(entry_hi),
      .dev_id(dev_id), .iova(iova), .op(op), .req_perm(req_perm), .excl_en(excl_en),
      .excl_hit(excl_hit), .out_valid(out_valid), .result(result), .grant_perm(grant_perm),
      .err_valid(err_valid), .err_cause(err_cause), .err_present(err_present),
      .err_rsvd(err_rsvd), .err_write(err_write), .err_intr(err_intr), .err_xlate(err_xlate),
      .err_dev_id(err_dev_id), .err_addr(err_addr)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // apply one request on a falling edge, sample one cycle later on the next falling edge
   task automatic issue(input logic [63:0] lo, input logic [63:0] hi, input logic [2:0] o,
                        input logic [1:0] p, input logic en, input logic hit, input logic [63:0] a);
      @(negedge clk);
      entry_lo = lo; entry_hi = hi; op = o; req_perm = p;
      excl_en = en; excl_hit = hit; iova = a; dev_id = 16'hBEEF;
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic t_reset;
      check("R13 out_valid", out_valid, 0);
      check("R13 result", result, 0);
      check("R13 grant", grant_perm, 0);
      check("R13 err_valid", err_valid, 0);
      check("R13 cause", err_cause, 0);
   endtask

   task automatic t_bypass;
      issue(64'h0000_0000_0000_0604, 64'h0, 3'd1, 2'b11, 0, 0, 64'h1000);
      check("R1 strobe", out_valid, 1);
      check("R2 result", result, 0);
      check("R2 grant", grant_perm, 2'b11);
      check("R2 err_valid", err_valid, 0);
      check("R2 dev", err_dev_id, 0);
      @(negedge clk);
      check("R1 single pulse", out_valid, 0);
   endtask

   task automatic t_rsvd_q0;
      issue(BASE | 64'h4, 64'h0, 3'd3, 2'b01, 1, 1, 64'h0000_1237);
      check("R3 result", result, 1);
      check("R3 cause", err_cause, 1);
      check("R3 rsvd", err_rsvd, 1);
      check("R3 present", err_present, 0);
      check("R3 grant", grant_perm, 0);
      check("R3 addr", err_addr, 64'h0000_1234);
      check("R6 rsvd outranks exclusion", result, 1);
      check("R12 xlate flag", err_xlate, 1);
   endtask

   task automatic t_feature;
      issue(BASE | (64'h1 << 52), 64'h0, 3'd0, 2'b01, 0, 0, 64'h40);
      check("R4 q0 feature bit", result, 1);
      issue(BASE | (64'h1 << 60), 64'h0, 3'd0, 2'b01, 0, 0, 64'h40);
      check("R4 q0 feature top bit", result, 1);
      issue(BASE, 64'h1 << 16, 3'd0, 2'b01, 0, 0, 64'h40);
      check("R4 q1 feature bit", result, 1);
   endtask

   task automatic t_rsvd_q1;
      issue(BASE, 64'h1 << 42, 3'd0, 2'b01, 0, 0, 64'h40);
      check("R5 q1 reserved", result, 1);
      issue(BASE, 64'h0000_0000_0000_ffff, 3'd0, 2'b01, 0, 0, 64'h40);
      check("R5 q1 low bits allowed", result, 4);
   endtask

   task automatic t_exclusion;
      issue(64'h6000_0000_0000_0601, 64'h0, 3'd0, 2'b01, 1, 1, 64'h80);
      check("R6 en+hit pass", result, 0);
      check("R6 en+hit no err", err_valid, 0);
      issue(64'h6000_0000_0000_0601, 64'h0, 3'd0, 2'b01, 1, 0, 64'h80);
      check("R6 en only no effect", result, 2);
      issue(64'h6000_0000_0000_0601, 64'h0, 3'd0, 2'b01, 0, 1, 64'h80);
      check("R6 hit only no effect", result, 2);
   endtask

   task automatic t_tv_off;
      issue(64'h6000_0000_0000_0601, 64'h0, 3'd1, 2'b10, 0, 0, 64'hDEAD_0003);
      check("R7 result", result, 2);
      check("R7 cause", err_cause, 2);
      check("R7 present", err_present, 0);
      check("R7 rsvd", err_rsvd, 0);
      check("R7 grant", grant_perm, 0);
      check("R12 write flag", err_write, 1);
      check("R12 intr flag", err_intr, 0);
      check("R12 dev id", err_dev_id, 16'hBEEF);
      check("R12 full addr", err_addr, 64'hDEAD_0003);
   endtask

   task automatic t_mode0;
      issue(64'h2000_0000_0000_0003, 64'h0, 3'd1, 2'b10, 0, 0, 64'h100);
      check("R8 result", result, 3);
      check("R8 grant read only", grant_perm, 2'b01);
      check("R8 no err", err_valid, 0);
   endtask

   task automatic t_level;
      issue(64'h6000_0000_0000_0E03, 64'h0, 3'd2, 2'b01, 0, 0, 64'h200);
      check("R9 result", result, 2);
      check("R9 cause", err_cause, 3);
      check("R9 present", err_present, 1);
      check("R12 intr flag", err_intr, 1);
      issue(64'h6000_0000_0000_0C03, 64'h0, 3'd0, 2'b01, 0, 0, 64'h200);
      check("R9 max level ok", result, 4);
   endtask

   task automatic t_perm;
      issue(64'h2000_0000_0000_0603, 64'h0, 3'd1, 2'b11, 0, 0, 64'h300);
      check("R10 write short result", result, 2);
      check("R10 write prot cause", err_cause, 5);
      check("R10 present", err_present, 1);
      check("R10 grant", grant_perm, 0);
      issue(64'h4000_0000_0000_0603, 64'h0, 3'd4, 2'b01, 0, 0, 64'h300);
      check("R10 read prot cause", err_cause, 4);
      check("R12 cmd flags", {err_write, err_intr, err_xlate}, 3'b000);
   endtask

   task automatic t_walk;
      issue(BASE, 64'h0, 3'd0, 2'b01, 0, 0, 64'h400);
      check("R11 result", result, 4);
      check("R11 grant", grant_perm, 2'b11);
      check("R11 no err", err_valid, 0);
      check("R11 cause", err_cause, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      check("R1 idle", out_valid, 0);
      t_bypass();
      t_rsvd_q0();
      t_feature();
      t_rsvd_q1();
      t_exclusion();
      t_tv_off();
      t_mode0();
      t_level();
      t_perm();
      t_walk();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule